// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the serial-interface side of a small NOR flash. It runs on the device's own clock and oversamples the host's serial clock, data-in, chip-select and hold pins. It finds the clock polarity at the moment of selection, assembles opcode, address and dummy bytes, and decodes each command. For array reads, status reads and both identification reads, it serialises the reply onto a data-out line with an enable. Array bytes come from a synchronous read port on a 19-bit address that advances by itself.

Commands that change the array or the configuration are not carried out here. They are passed on as a one-cycle request that holds the opcode and the address, and any payload bytes go out as separate strobes. A power-down state is kept locally, and so is a hold state that pauses the transfer.

Top module: `sflash_frontend`

## Requirements
- R1: After reset, soe_o, pd_o, wr_req_o, dat_valid_o and mem_rd_o are all 0.
- R2: When chip select falls, mode3_o captures the serial clock level: 0 when the clock is low, 1 when it is high. In both modes, input bits are taken on rising clock edges and output bits change on falling edges.
- R3: Opcode 03h is followed by three address bytes, most significant first. The reply is the array bytes at that address and the addresses after it, each byte MSB first, with the first bit driven on the falling edge right after the last address bit.
- R4: Only the low 19 address bits are used, so the upper 5 bits of the 24-bit address are ignored. Reading past 7FFFFh continues at 00000h.
- R5: Opcode 0Bh takes three address bytes and then one dummy byte before the array data starts.
- R6: Opcode 05h returns status_i MSB first. The same byte repeats for as long as the clock runs, and the command is served even while wr_busy_i is 1.
- R7: Opcode 9Fh returns 62h, 16h, 13h, 00h and then repeats that cycle. While wr_busy_i is 1 the command is rejected, and soe_o stays 0.
- R8: Opcode ABh followed by three dummy bytes returns 3Eh on every later byte.
- R9: Opcode B9h sets pd_o when chip select rises, but only if wr_busy_i is 0 at that moment. While pd_o is 1, every opcode except ABh is ignored, so soe_o stays 0 and no request is raised. Completing an ABh opcode byte clears pd_o.
- R10: With chip select low, a falling hold line while the clock is low freezes the transfer and forces soe_o to 0. Clock edges during the hold are ignored, and a rising hold line resumes the transfer at the same bit.
- R11: soe_o is 0 whenever chip select is high. A chip-select rise throws away a partly shifted byte, and the next selection starts with a fresh opcode.
- R12: The write-type opcodes are 06h, 04h, 60h, C7h, 01h (no address) and 02h, 20h, D7h, D8h (three address bytes). Each one raises wr_req_o for one cycle, with wr_op_o and wr_addr_o, when chip select rises on a byte boundary. A rise in mid-byte raises nothing. Each payload byte after the header of 01h or 02h is strobed on dat_valid_o and dat_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| si_i | input | 1 | Serial data in |
| cs_n_i | input | 1 | Chip select, active low |
| hold_n_i | input | 1 | Hold, active low |
| wr_busy_i | input | 1 | An internal write or erase is running |
| status_i | input | 8 | Status byte to be returned by 05h |
| mem_rd_o | output | 1 | Array read strobe |
| mem_addr_o | output | 19 | Array read address |
| mem_rdata_i | input | 8 | Array read data, one cycle after the strobe |
| so_o | output | 1 | Serial data out |
| soe_o | output | 1 | Output enable for so_o |
| mode3_o | output | 1 | Clock polarity captured at selection |
| pd_o | output | 1 | Power-down state |
| wr_req_o | output | 1 | Write-type command request strobe |
| wr_op_o | output | 8 | Opcode of the request |
| wr_addr_o | output | 19 | Address of the request |
| dat_valid_o | output | 1 | Payload byte strobe |
| dat_o | output | 8 | Payload byte |

## Verification
Every pin change is seen three clocks later: two synchroniser stages plus one edge-detect register. A falling serial clock edge therefore updates so_o by the fourth clock, and an array byte is loaded into the transmit register four clocks after the byte boundary that requests it. The bench holds each serial clock phase for eight clocks and reads so_o just before it raises the clock, which leaves margin over both latencies. pd_o and wr_req_o become valid a few clocks after chip select rises, so the bench checks them two half-periods after deselection. Expected reply bytes are queued when a command is issued and compared in order as the bytes are shifted in.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_TAIL, PH_OUT, PH_IGN
  } phase_t;

  typedef enum logic [1:0] {SRC_ARRAY, SRC_STAT, SRC_JEDEC, SRC_SIG} src_t;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_RDST  = 8'h05;
  localparam logic [7:0] OP_JID   = 8'h9F;
  localparam logic [7:0] OP_SIG   = 8'hAB;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_WRST  = 8'h01;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERS4A = 8'h20;
  localparam logic [7:0] OP_ERS4B = 8'hD7;
  localparam logic [7:0] OP_ERS64 = 8'hD8;
  localparam logic [7:0] OP_ERSA  = 8'h60;
  localparam logic [7:0] OP_ERSB  = 8'hC7;

  localparam logic [7:0] SIG_CODE = 8'h3E;

  function automatic logic [7:0] jedec_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    jedec_byte = 8'h62;
      2'd1:    jedec_byte = 8'h16;
      2'd2:    jedec_byte = 8'h13;
      default: jedec_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sflash_sync.sv
module sflash_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[g] <= RST_VAL;
          else     st[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[g] <= RST_VAL;
          else     st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/sflash_rx.sv
module sflash_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       si,
  input  logic       cs_n,
  input  logic       hold_n,
  output logic       fall_o,
  output logic       byte_done_o,
  output logic [7:0] byte_o,
  output logic       cs_rise_o,
  output logic       aligned_o,
  output logic       held_o,
  output logic       mode3_o
);
  logic       sck_q, cs_q, hold_q, held, mode3;
  logic [2:0] bidx;
  logic [6:0] sh;
  logic       active, rise;

  assign active      = ~cs_n & ~held;
  assign rise        = active & sck & ~sck_q;
  assign fall_o      = active & ~sck & sck_q;
  assign byte_done_o = rise & (bidx == 3'd7);
  assign byte_o      = {sh, si};
  assign cs_rise_o   = cs_n & ~cs_q;
  assign aligned_o   = (bidx == 3'd0);
  assign held_o      = held;
  assign mode3_o     = mode3;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0; cs_q <= 1'b1; hold_q <= 1'b1;
      held <= 1'b0; mode3 <= 1'b0; bidx <= '0; sh <= '0;
    end else begin
      sck_q  <= sck;
      cs_q   <= cs_n;
      hold_q <= hold_n;
      if (cs_q && !cs_n) mode3 <= sck;
      if (cs_n) begin
        held <= 1'b0;
        bidx <= '0;
      end else begin
        if (hold_q && !hold_n && !sck) held <= 1'b1;
        else if (!hold_q && hold_n)    held <= 1'b0;
        if (rise) begin
          bidx <= bidx + 3'd1;
          sh   <= {sh[5:0], si};
        end
      end
    end
  end

  a_r11_bits_clear: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (bidx == 3'd0));
  a_r2_mode_capture: assert property (@(posedge clk) disable iff (rst)
    (cs_q && !cs_n) |=> (mode3 == $past(sck)));
  a_r10_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    (held && !cs_n) |=> $stable(bidx));
endmodule

// File: rtl/sflash_frontend.sv
module sflash_frontend
  import sflash_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              cs_n_i,
  input  logic              hold_n_i,
  input  logic              wr_busy_i,
  input  logic [7:0]        status_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              so_o,
  output logic              soe_o,
  output logic              mode3_o,
  output logic              pd_o,
  output logic              wr_req_o,
  output logic [7:0]        wr_op_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              dat_valid_o,
  output logic [7:0]        dat_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic sck_s, si_s, cs_s, hold_s;
  logic rx_fall, rx_done, rx_cs_rise, rx_aligned, rx_held;
  logic [7:0] rx_byte;

  sflash_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst(rst),
    .d({hold_n_i, cs_n_i, si_i, sck_i}),
    .q({hold_s, cs_s, si_s, sck_s})
  );

  sflash_rx u_rx (
    .clk(clk), .rst(rst), .sck(sck_s), .si(si_s), .cs_n(cs_s), .hold_n(hold_s),
    .fall_o(rx_fall), .byte_done_o(rx_done), .byte_o(rx_byte),
    .cs_rise_o(rx_cs_rise), .aligned_o(rx_aligned), .held_o(rx_held),
    .mode3_o(mode3_o)
  );

  phase_t            phase;
  src_t              src;
  logic [7:0]        op, tx_byte;
  logic [ADDR_W-1:0] abuf, rd_addr, abuf_nx;
  logic [1:0]        acnt, jidx;
  logic [2:0]        tx_idx;
  logic              armed, f1, f2, f3;

  assign abuf_nx = {abuf[ADDR_W-9:0], rx_byte};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CMD; src <= SRC_ARRAY; op <= '0; tx_byte <= '0;
      abuf <= '0; rd_addr <= '0; acnt <= '0; jidx <= '0; tx_idx <= '0;
      armed <= 1'b0; f1 <= 1'b0; f2 <= 1'b0; f3 <= 1'b0;
      mem_rd_o <= 1'b0; mem_addr_o <= '0; so_o <= 1'b0; soe_o <= 1'b0;
      pd_o <= 1'b0; wr_req_o <= 1'b0; wr_op_o <= '0; wr_addr_o <= '0;
      dat_valid_o <= 1'b0; dat_o <= '0;
    end else begin
      f1 <= 1'b0; f2 <= f1; f3 <= f2;
      mem_rd_o <= 1'b0; wr_req_o <= 1'b0; dat_valid_o <= 1'b0;
      soe_o <= ~cs_s & ~rx_held & (phase == PH_OUT);

      if (f1) begin
        mem_rd_o   <= (src == SRC_ARRAY);
        mem_addr_o <= rd_addr;
        if (src == SRC_ARRAY) rd_addr <= rd_addr + ADDR_ONE;
      end
      if (f3) begin
        case (src)
          SRC_ARRAY: tx_byte <= mem_rdata_i;
          SRC_STAT:  tx_byte <= status_i;
          SRC_JEDEC: begin tx_byte <= jedec_byte(jidx); jidx <= jidx + 2'd1; end
          default:   tx_byte <= SIG_CODE;
        endcase
      end

      if (cs_s) begin
        phase <= PH_CMD; acnt <= '0; armed <= 1'b0; tx_idx <= '0; so_o <= 1'b0;
        if (rx_cs_rise && armed && rx_aligned) begin
          if (op == OP_SLEEP) begin
            if (!wr_busy_i) pd_o <= 1'b1;
          end else begin
            wr_req_o  <= 1'b1;
            wr_op_o   <= op;
            wr_addr_o <= abuf;
          end
        end
      end else begin
        if (rx_fall && phase == PH_OUT) begin
          so_o   <= tx_byte[3'd7 - tx_idx];
          tx_idx <= tx_idx + 3'd1;
          if (tx_idx == 3'd7) f1 <= 1'b1;
        end
        if (rx_done) begin
          case (phase)
            PH_CMD: begin
              op <= rx_byte;
              if (pd_o && rx_byte != OP_SIG) phase <= PH_IGN;
              else begin
                case (rx_byte)
                  OP_READ, OP_FREAD, OP_PROG, OP_ERS4A, OP_ERS4B, OP_ERS64:
                    phase <= PH_ADDR;
                  OP_RDST: begin
                    phase <= PH_OUT; src <= SRC_STAT; f1 <= 1'b1; tx_idx <= '0;
                  end
                  OP_JID: begin
                    if (wr_busy_i) phase <= PH_IGN;
                    else begin
                      phase <= PH_OUT; src <= SRC_JEDEC; f1 <= 1'b1;
                      tx_idx <= '0; jidx <= '0;
                    end
                  end
                  OP_SIG: begin
                    if (wr_busy_i) phase <= PH_IGN;
                    else begin pd_o <= 1'b0; phase <= PH_ADDR; end
                  end
                  OP_SLEEP, OP_WEN, OP_WDIS, OP_ERSA, OP_ERSB: begin
                    phase <= PH_TAIL; armed <= 1'b1;
                  end
                  OP_WRST: begin phase <= PH_DATA; armed <= 1'b1; end
                  default: phase <= PH_IGN;
                endcase
              end
            end
            PH_ADDR: begin
              abuf <= abuf_nx;
              acnt <= acnt + 2'd1;
              if (acnt == 2'd2) begin
                case (op)
                  OP_READ: begin
                    phase <= PH_OUT; src <= SRC_ARRAY; rd_addr <= abuf_nx;
                    f1 <= 1'b1; tx_idx <= '0;
                  end
                  OP_FREAD: phase <= PH_DUMMY;
                  OP_SIG: begin
                    phase <= PH_OUT; src <= SRC_SIG; f1 <= 1'b1; tx_idx <= '0;
                  end
                  OP_PROG: begin phase <= PH_DATA; armed <= 1'b1; end
                  default: begin phase <= PH_TAIL; armed <= 1'b1; end
                endcase
              end
            end
            PH_DUMMY: begin
              phase <= PH_OUT; src <= SRC_ARRAY; rd_addr <= abuf;
              f1 <= 1'b1; tx_idx <= '0;
            end
            PH_DATA: begin
              dat_valid_o <= 1'b1;
              dat_o       <= rx_byte;
            end
            default: ;
          endcase
        end
      end
    end
  end

  a_r11_soe_idle: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !soe_o);
  a_r10_soe_hold: assert property (@(posedge clk) disable iff (rst)
    rx_held |=> !soe_o);
  a_r9_sleep_not_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_o) |-> $past(!wr_busy_i));
  a_r12_req_on_deselect: assert property (@(posedge clk) disable iff (rst)
    wr_req_o |-> $past(rx_cs_rise));
endmodule

// File: tb/tb_sflash_frontend.sv
module tb_sflash_frontend;
  localparam int H = 8;
  localparam int AW = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] status = 8'hA5;
  logic mem_rd_o, so_o, soe_o, mode3_o, pd_o, wr_req_o, dat_valid_o;
  logic [AW-1:0] mem_addr_o, wr_addr_o;
  logic [7:0] mem_rdata = 8'h00, wr_op_o, dat_o;

  always #10 clk = ~clk;

  sflash_frontend dut (
    .clk(clk), .rst(rst), .sck_i(sck), .si_i(si), .cs_n_i(cs_n),
    .hold_n_i(hold_n), .wr_busy_i(busy), .status_i(status),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata),
    .so_o(so_o), .soe_o(soe_o), .mode3_o(mode3_o), .pd_o(pd_o),
    .wr_req_o(wr_req_o), .wr_op_o(wr_op_o), .wr_addr_o(wr_addr_o),
    .dat_valid_o(dat_valid_o), .dat_o(dat_o)
  );

  function automatic logic [7:0] memb(input logic [AW-1:0] a);
    memb = a[7:0] ^ 8'h5A ^ {a[18:16], 5'b0};
  endfunction

  always @(posedge clk) if (mem_rd_o) mem_rdata <= memb(mem_addr_o);

  int wr_cnt = 0, dat_cnt = 0;
  logic [7:0] last_op = '0, last_dat = '0;
  logic [AW-1:0] last_addr = '0;
  always @(posedge clk) begin
    if (wr_req_o) begin wr_cnt <= wr_cnt + 1; last_op <= wr_op_o; last_addr <= wr_addr_o; end
    if (dat_valid_o) begin dat_cnt <= dat_cnt + 1; last_dat <= dat_o; end
  end

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] exp_v[$];
  string      exp_tag[$];
  logic [8:0] got_q[$];

  always @(negedge clk) begin
    while (got_q.size() > 0 && exp_v.size() > 0) begin
      logic [8:0] g;
      logic [7:0] e;
      string t;
      g = got_q.pop_front();
      e = exp_v.pop_front();
      t = exp_tag.pop_front();
      chk(t, {23'd0, g}, {23'd0, 1'b1, e});
    end
  end

  task automatic wcy(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit cur_m3 = 0;
  task automatic sel(input bit m3);
    cur_m3 = m3; sck = m3; wcy(H); cs_n = 1'b0; wcy(H);
  endtask
  task automatic desel();
    if (!cur_m3) begin sck = 1'b0; wcy(H); end
    cs_n = 1'b1; wcy(2*H);
  endtask
  task automatic put(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = b[i]; wcy(H); sck = 1'b1; wcy(H);
    end
  endtask
  task automatic get(output logic [7:0] b, output logic oe);
    oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; wcy(H); b[i] = so_o; oe = oe & soe_o; sck = 1'b1; wcy(H);
    end
  endtask
  task automatic expect_rd(input string tag, input logic [7:0] e);
    logic [7:0] b;
    logic oe;
    exp_v.push_back(e); exp_tag.push_back(tag);
    get(b, oe);
    got_q.push_back({oe, b});
  endtask
  task automatic addr3(input logic [23:0] a);
    put(a[23:16]); put(a[15:8]); put(a[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic oe;
    int base;
    wcy(5); rst = 1'b0; wcy(3);
    // R1 reset state
    chk("R1 soe", {31'd0, soe_o}, 0);
    chk("R1 pd", {31'd0, pd_o}, 0);
    chk("R1 strobes", {29'd0, wr_req_o, dat_valid_o, mem_rd_o}, 0);

    // R2 mode 0, R6 status repeats
    sel(0);
    chk("R2 mode0", {31'd0, mode3_o}, 0);
    put(8'h05);
    expect_rd("R6 status b0", 8'hA5);
    expect_rd("R6 status b1", 8'hA5);
    desel();

    // R2 mode 3, R3 read, R4 upper bits ignored
    sel(1);
    chk("R2 mode3", {31'd0, mode3_o}, 1);
    put(8'h03); addr3(24'hF80010);
    expect_rd("R3 rd0", memb(19'h00010));
    expect_rd("R3 rd1", memb(19'h00011));
    expect_rd("R3 rd2", memb(19'h00012));
    desel();

    // R4 wrap
    sel(0); put(8'h03); addr3(24'h07FFFE);
    expect_rd("R4 top-1", memb(19'h7FFFE));
    expect_rd("R4 top", memb(19'h7FFFF));
    expect_rd("R4 wrap", memb(19'h00000));
    desel();

    // R5 fast read
    sel(0); put(8'h0B); addr3(24'h000100); put(8'hFF);
    expect_rd("R5 f0", memb(19'h00100));
    expect_rd("R5 f1", memb(19'h00101));
    desel();

    // R7 JEDEC sequence
    sel(0); put(8'h9F);
    expect_rd("R7 id0", 8'h62); expect_rd("R7 id1", 8'h16);
    expect_rd("R7 id2", 8'h13); expect_rd("R7 id3", 8'h00);
    expect_rd("R7 id4", 8'h62);
    desel();

    // R8 signature
    sel(1); put(8'hAB); addr3(24'h000000);
    expect_rd("R8 sig0", 8'h3E); expect_rd("R8 sig1", 8'h3E);
    desel();

    // busy: R6 status allowed, R7 rejected, R9 sleep ignored
    busy = 1'b1; status = 8'h3C;
    sel(0); put(8'h05); expect_rd("R6 busy status", 8'h3C); desel();
    sel(0); put(8'h9F); get(b, oe); chk("R7 busy reject", {31'd0, oe}, 0); desel();
    sel(0); put(8'hB9); desel();
    chk("R9 busy sleep ignored", {31'd0, pd_o}, 0);
    busy = 1'b0;

    // R9 power-down
    sel(0); put(8'hB9); desel();
    chk("R9 pd set", {31'd0, pd_o}, 1);
    sel(0); put(8'h05); get(b, oe); chk("R9 pd rejects 05", {31'd0, oe}, 0); desel();
    base = wr_cnt;
    sel(0); put(8'h06); desel();
    chk("R9 pd rejects 06", wr_cnt - base, 0);
    sel(0); put(8'hAB);
    chk("R9 pd exit", {31'd0, pd_o}, 0);
    addr3(24'h0); expect_rd("R9 sig after exit", 8'h3E);
    desel();

    // R10 hold
    sel(0); put(8'h03); addr3(24'h000020);
    expect_rd("R10 before hold", memb(19'h00020));
    sck = 1'b0; wcy(H);
    hold_n = 1'b0; wcy(H);
    chk("R10 soe off", {31'd0, soe_o}, 0);
    sck = 1'b1; wcy(H); sck = 1'b0; wcy(H); sck = 1'b1; wcy(H); sck = 1'b0; wcy(H);
    hold_n = 1'b1; wcy(H);
    expect_rd("R10 resumed", memb(19'h00021));
    desel();

    // R11 soe idle, partial byte discarded
    chk("R11 soe idle", {31'd0, soe_o}, 0);
    sel(0);
    for (int i = 0; i < 3; i++) begin sck = 1'b0; si = 1'b1; wcy(H); sck = 1'b1; wcy(H); end
    desel();
    sel(0); put(8'h9F); expect_rd("R11 fresh opcode", 8'h62); desel();

    // R12 handoff
    base = wr_cnt;
    sel(0); put(8'h06); desel();
    chk("R12 wen req", wr_cnt - base, 1);
    chk("R12 wen op", {24'd0, last_op}, 32'h06);
    sel(0); put(8'h20); addr3(24'h012345); desel();
    chk("R12 erase op", {24'd0, last_op}, 32'h20);
    chk("R12 erase addr", {13'd0, last_addr}, 32'h12345);
    base = dat_cnt;
    sel(0); put(8'h02); addr3(24'h000200); put(8'hAA); put(8'hBB); desel();
    chk("R12 prog data count", dat_cnt - base, 2);
    chk("R12 prog last data", {24'd0, last_dat}, 32'hBB);
    chk("R12 prog op", {24'd0, last_op}, 32'h02);
    chk("R12 prog addr", {13'd0, last_addr}, 32'h00200);
    base = wr_cnt;
    sel(0); put(8'h06);
    for (int i = 0; i < 3; i++) begin sck = 1'b0; si = 1'b0; wcy(H); sck = 1'b1; wcy(H); end
    desel();
    chk("R12 misaligned no req", wr_cnt - base, 0);

    wcy(4);
    chk("scoreboard drained", exp_v.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule